// File: doc/BRIEF.md
# Address Window Decoder

This block decides, for every bus address presented to it, whether the address lies inside a window that software has opened. A single 32-bit select register holds all the window enables. The upper sixteen bits each open one 256 MB coarse region, and together they span the whole 4 GB space. The lower sixteen bits each open one 16 MB fine slice inside the topmost 256 MB region. This lets a system open large areas and a few small ones with one register.

The register sits on a small configuration port. The port has a write strobe, per-byte lane enables and a combinational read. The decode path takes an address and returns an overall hit flag, a separate flag for each hit source and a window index. By default the decode is combinational. A parameter can add one register stage on the decode result.

Top module: `addr_window_decoder`

## Requirements
- R1: While reset is active and after reset is released, the select register is all zeros. Reads at the select offset return zero and no address hits until a write opens a window.
- R2: The select register answers only at configuration offset 0x48. Writes at any other offset leave it unchanged, and reads at any other offset return zero.
- R3: Byte lanes are little-endian. cfg_be[k] enables the write of register bits 8k+7 down to 8k, and bytes whose enable is low keep their value.
- R4: Register bit 16+n opens coarse region n, which holds the addresses whose bits 31:28 equal n. An address in an open coarse region raises win_coarse.
- R5: Register bit m opens fine slice m, which holds the addresses whose bits 31:28 are all ones and whose bits 27:24 equal m. An address in an open fine slice raises win_fine.
- R6: win_hit is high exactly when win_coarse or win_fine is high. The two sources are reported independently, so both can be high together.
- R7: When win_coarse is high, win_idx is the coarse region number n (0 to 15). Otherwise, when win_fine is high, win_idx is 16+m. With no hit, win_idx is 0. The coarse hit takes precedence.
- R8: A register write at a clock edge affects decode only from that edge onward. An address decoded in the same cycle as the write still sees the old register value.
- R9: With REG_OUT=0, the decode outputs follow bus_addr in the same cycle. With REG_OUT=1, they present the decode of the address and register value sampled at the previous clock edge, and they are zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Write byte-lane enables, bit k selects bits 8k+7:8k |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| bus_addr | input | 32 | Address to decode |
| win_hit | output | 1 | Address falls in an open window |
| win_coarse | output | 1 | Hit from a coarse region enable |
| win_fine | output | 1 | Hit from a fine slice enable |
| win_idx | output | 5 | Window index: region number, or 16 plus slice number |

## Verification
The assertions assume that cfg_we, cfg_addr, cfg_be and bus_addr are known and stable around each rising clock edge, and that reset is applied from time zero. The checks on the window source look at the pre-stage decode. They therefore hold for both settings of REG_OUT. The bench drives every input on the falling edge so that each value is settled before the next rising edge. It never leaves an input undriven after reset starts. Random writes target the select offset and a neighbouring offset, which keeps the wrong-offset case within the assumed input set.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int CFG_W       = 32;
  localparam int CFG_AW      = 8;
  localparam int LANES       = CFG_W / 8;
  localparam int REGION_BITS = 4;
  localparam int NUM_REGIONS = 1 << REGION_BITS;
  localparam int IDX_W       = REGION_BITS + 1;
  localparam int COARSE_LSB  = CFG_W / 2;

  typedef struct packed {
    logic             hit;
    logic             coarse;
    logic             fine;
    logic [IDX_W-1:0] idx;
  } awd_result_t;

  // region number taken from the top address bits
  function automatic logic [REGION_BITS-1:0] region_of(input logic [31:0] a);
    return a[31 -: REGION_BITS];
  endfunction

  // fine slice number taken from the bits just below the region field
  function automatic logic [REGION_BITS-1:0] slice_of(input logic [31:0] a);
    return a[31-REGION_BITS -: REGION_BITS];
  endfunction

  // index code: coarse region n -> n, fine slice m -> NUM_REGIONS + m
  function automatic logic [IDX_W-1:0] make_idx(input logic is_fine,
                                                input logic [REGION_BITS-1:0] n);
    return {is_fine, n};
  endfunction
endpackage

// File: rtl/awd_cfg_reg.sv
module awd_cfg_reg
  import awd_pkg::*;
#(
  parameter logic [CFG_AW-1:0] OFFSET = 8'h48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  input  logic [LANES-1:0]  be,
  output logic [CFG_W-1:0]  q,
  output logic [CFG_W-1:0]  rdata,
  output logic              wr_sel
);
  logic addr_match;
  assign addr_match = (addr == OFFSET);
  assign wr_sel     = we && addr_match;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_we;
    assign lane_we = wr_sel && be[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[8*k +: 8] <= '0;
      else if (lane_we) q[8*k +: 8] <= wdata[8*k +: 8];
    end
  end

  assign rdata = addr_match ? q : '0;
endmodule

// File: rtl/awd_window_match.sv
module awd_window_match
  import awd_pkg::*;
(
  input  logic [CFG_W-1:0] sel,
  input  logic [31:0]      addr,
  output logic             coarse_hit,
  output logic             fine_hit,
  output logic [IDX_W-1:0] idx
);
  logic [REGION_BITS-1:0] region_n;
  logic [REGION_BITS-1:0] slice_n;
  logic                   in_top;
  logic [NUM_REGIONS-1:0] coarse_vec;
  logic [NUM_REGIONS-1:0] fine_vec;

  assign region_n = region_of(addr);
  assign slice_n  = slice_of(addr);
  assign in_top   = &region_n;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_win
    assign coarse_vec[i] = sel[COARSE_LSB + i] && (region_n == i[REGION_BITS-1:0]);
    assign fine_vec[i]   = sel[i] && in_top && (slice_n == i[REGION_BITS-1:0]);
  end

  assign coarse_hit = |coarse_vec;
  assign fine_hit   = |fine_vec;

  always_comb begin
    idx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (fine_vec[i]) idx = make_idx(1'b1, REGION_BITS'(i));
    end
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (coarse_vec[i]) idx = make_idx(1'b0, REGION_BITS'(i));
    end
  end
endmodule

// File: rtl/awd_out_stage.sv
module awd_out_stage
  import awd_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  awd_result_t d,
  output awd_result_t q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end else begin : g_comb
    assign q = d;
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter logic [CFG_AW-1:0] CFG_OFFSET = 8'h48,
  parameter bit                REG_OUT    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [LANES-1:0]  cfg_be,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [31:0]       bus_addr,
  output logic              win_hit,
  output logic              win_coarse,
  output logic              win_fine,
  output logic [IDX_W-1:0]  win_idx
);
  logic [CFG_W-1:0] sel_q;
  logic             sel_wr;
  logic             raw_coarse;
  logic             raw_fine;
  logic [IDX_W-1:0] raw_idx;
  awd_result_t      raw_res;
  awd_result_t      out_res;

  awd_cfg_reg #(.OFFSET(CFG_OFFSET)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .be(cfg_be), .q(sel_q), .rdata(cfg_rdata),
    .wr_sel(sel_wr)
  );

  awd_window_match u_match (
    .sel(sel_q), .addr(bus_addr),
    .coarse_hit(raw_coarse), .fine_hit(raw_fine), .idx(raw_idx)
  );

  always_comb begin
    raw_res.coarse = raw_coarse;
    raw_res.fine   = raw_fine;
    raw_res.hit    = raw_coarse | raw_fine;
    raw_res.idx    = raw_idx;
  end

  awd_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .d(raw_res), .q(out_res)
  );

  assign win_hit    = out_res.hit;
  assign win_coarse = out_res.coarse;
  assign win_fine   = out_res.fine;
  assign win_idx    = out_res.idx;
endmodule

// File: rtl/awd_checker.sv
module awd_checker
  import awd_pkg::*;
#(
  parameter logic [CFG_AW-1:0] OFFSET = 8'h48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [LANES-1:0]  cfg_be,
  input logic [CFG_W-1:0]  sel_q,
  input logic [31:0]       bus_addr,
  input logic              raw_coarse,
  input logic              raw_fine,
  input logic [IDX_W-1:0]  raw_idx
);
  logic [REGION_BITS-1:0] reg_n;
  logic [REGION_BITS-1:0] sub_n;
  assign reg_n = bus_addr[31 -: REGION_BITS];
  assign sub_n = bus_addr[31-REGION_BITS -: REGION_BITS];

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> sel_q == '0);

  // R3
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFFSET && cfg_be == '1) |=> sel_q == $past(cfg_wdata));

  // R2
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr != OFFSET) |=> $stable(sel_q));

  // R4
  coarse_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_coarse |-> sel_q[COARSE_LSB + int'(reg_n)]);

  // R5
  fine_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_fine |-> (reg_n == '1 && sel_q[sub_n]));

  // R7
  idx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(raw_coarse || raw_fine) |-> raw_idx == '0);

  // R7
  idx_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_coarse |-> raw_idx == {1'b0, reg_n});
endmodule

bind addr_window_decoder awd_checker #(.OFFSET(CFG_OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .sel_q(sel_q),
  .bus_addr(bus_addr), .raw_coarse(raw_coarse), .raw_fine(raw_fine),
  .raw_idx(raw_idx)
);

// File: tb/sim_addr_window_decoder.sv
module sim_addr_window_decoder;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] bus_addr = '0;
  logic [31:0] rd0, rd1;
  logic        h0, c0, f0, h1, c1, f1;
  logic [4:0]  i0, i1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  logic [31:0] m_sel = '0;
  logic [7:0]  exp_reg = '0;   // {hit, coarse, fine, idx} of registered copy

  always #(CLK_P/2) clk = ~clk;

  addr_window_decoder #(.REG_OUT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(rd0),
    .bus_addr(bus_addr), .win_hit(h0), .win_coarse(c0), .win_fine(f0), .win_idx(i0));

  addr_window_decoder #(.REG_OUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(rd1),
    .bus_addr(bus_addr), .win_hit(h1), .win_coarse(c1), .win_fine(f1), .win_idx(i1));

  // behavioural decode: returns {hit, coarse, fine, idx[4:0]}
  function automatic logic [7:0] ref_decode(input logic [31:0] sel, input logic [31:0] a);
    int region, slice, idx;
    bit c, f;
    region = int'(a / 32'h1000_0000);
    slice  = int'((a % 32'h1000_0000) / 32'h0100_0000);
    c = sel[16 + region];
    f = (region == 15) && sel[slice];
    idx = c ? region : (f ? 16 + slice : 0);
    return {c | f, c, f, idx[4:0]};
  endfunction

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model advances on each rising edge, using pre-edge values
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel   = '0;
      exp_reg = '0;
    end else begin
      exp_reg = ref_decode(m_sel, bus_addr);
      if (cfg_we && cfg_addr == 8'h48)
        for (int k = 0; k < 4; k++)
          if (cfg_be[k]) m_sel[8*k +: 8] = cfg_wdata[8*k +: 8];
    end
  end

  // every-cycle comparison against the model
  task automatic compare_all();
    expect_eq("R6 R7 comb decode", {24'h0, h0, c0, f0, i0}, {24'h0, ref_decode(m_sel, bus_addr)});
    expect_eq("R9 registered decode", {24'h0, h1, c1, f1, i1}, {24'h0, exp_reg});
    expect_eq("R2 read data", rd0, (cfg_addr == 8'h48) ? m_sel : 32'h0);
  endtask

  task automatic drive(input logic we, input logic [7:0] a, input logic [31:0] wd,
                       input logic [3:0] be, input logic [31:0] ba);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = wd; cfg_be = be; bus_addr = ba;
    #1;
    compare_all();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    drive(1'b0, 8'h48, '0, '0, 32'hF500_0000);
    drive(1'b0, 8'h48, '0, '0, 32'h3000_0000);
    expect_eq("R1 reset rdata", rd0, 32'h0);
    expect_eq("R1 reset hit", {31'h0, h0}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 8'h48, '0, '0, 32'hF000_0000);
    expect_eq("R1 after reset no hit", {31'h0, h0 | h1}, 32'h0);

    // R4: open coarse regions 0 and 2 through upper lanes only
    drive(1'b1, 8'h48, 32'h0005_0000, 4'b1100, 32'h2000_0000);
    drive(1'b0, 8'h48, '0, '0, 32'h2123_4567);
    expect_eq("R4 coarse region 2 hit", {24'h0, h0, c0, f0, i0}, {24'h0, 1'b1, 1'b1, 1'b0, 5'd2});
    drive(1'b0, 8'h48, '0, '0, 32'h1000_0000);
    expect_eq("R4 closed region 1 miss", {31'h0, h0}, 32'h0);

    // R5: open fine slices 0 and 3
    drive(1'b1, 8'h48, 32'h0000_0009, 4'b0011, 32'h0);
    drive(1'b0, 8'h48, '0, '0, 32'hF3AB_CDEF);
    expect_eq("R5 fine slice 3 hit", {24'h0, h0, c0, f0, i0}, {24'h0, 1'b1, 1'b0, 1'b1, 5'd19});
    drive(1'b0, 8'h48, '0, '0, 32'hF100_0000);
    expect_eq("R5 closed slice 1 miss", {31'h0, h0}, 32'h0);
    drive(1'b0, 8'h48, '0, '0, 32'h0300_0000);
    expect_eq("R5 slice bits outside top region", {31'h0, f0}, 32'h0);

    // R2: write at another offset is ignored, read there returns zero
    drive(1'b1, 8'h4C, 32'hFFFF_FFFF, 4'hF, 32'h0);
    drive(1'b0, 8'h4C, '0, '0, 32'h0);
    expect_eq("R2 foreign offset read", rd0, 32'h0);
    drive(1'b0, 8'h48, '0, '0, 32'h0);
    expect_eq("R2 register unchanged", rd0, 32'h0005_0009);

    // R3: only byte lane 0 written
    drive(1'b1, 8'h48, 32'hFFFF_FF40, 4'b0001, 32'h0);
    drive(1'b0, 8'h48, '0, '0, 32'h0);
    expect_eq("R3 single lane write", rd0, 32'h0005_0040);

    // R7: coarse region 15 and fine slice 6 both open, coarse index wins
    drive(1'b1, 8'h48, 32'h8005_0040, 4'b1111, 32'h0);
    drive(1'b0, 8'h48, '0, '0, 32'hF600_0010);
    expect_eq("R6 R7 both sources", {24'h0, h0, c0, f0, i0}, {24'h0, 1'b1, 1'b1, 1'b1, 5'd15});

    // R8: write and decode in the same cycle
    drive(1'b1, 8'h48, 32'h8025_0040, 4'b1100, 32'h5000_0000);
    expect_eq("R8 same cycle old value", {31'h0, h0}, 32'h0);
    drive(1'b0, 8'h48, '0, '0, 32'h5000_0000);
    expect_eq("R8 next cycle new value", {31'h0, h0}, 32'h1);

    // R9: registered copy shows previous cycle's decode
    drive(1'b0, 8'h48, '0, '0, 32'h7000_0000);
    expect_eq("R9 registered lag", {31'h0, h1}, 32'h1);

    // random traffic, compared every cycle
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra;
      ra = $urandom;
      if (n % 3 == 0) ra[31:28] = 4'hF;
      drive(($urandom % 4) == 0, ($urandom % 2) ? 8'h48 : 8'h4C,
            $urandom, 4'($urandom), ra);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule